// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a double-data-rate SDRAM from power-on to a usable state. After reset it holds the clock enable low and keeps the command bus at NOP until a start strobe arrives. It then waits a programmed stabilization time of at least 200 µs, converted to clock cycles, and raises the clock enable while the bus stays at NOP. It then drives a fixed chain of commands, each followed by a counted gap: a precharge of all banks, a write to the extended mode register that turns the delay-locked loop on, a write to the base mode register that resets the loop and loads the operating parameters, a second precharge of all banks, two auto refresh commands, and a final base mode register write with the loop-reset bit cleared.

The two mode register values are taken from input ports and are captured on the start strobe. The sequencer sets or clears the loop-related bits itself. The ready flag rises only when the final write has had its full gap and at least the loop lock time has passed since the loop-reset write. After that, the bus stays at NOP until the next reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until `start` is seen, `cke` is 0, the command lines {cs_n,ras_n,cas_n,we_n} are 4'b0111 (NOP), `ba` and `addr` are 0, and `init_done` is 0.
- R2: The cycle in which `start` is sampled is cycle 0. From cycle 0, `cke` stays 0 with NOP on the bus for exactly T_STABLE cycles. It is 1 from cycle T_STABLE onward, and every cycle with `cke` low carries NOP.
- R3: After `cke` rises, the only non-NOP commands are these, in this order: precharge-all, extended register write, base register write with loop reset, precharge-all, auto refresh, auto refresh, base register write without loop reset. Every precharge drives `addr[10]`=1 and all other address bits 0.
- R4: The first precharge comes T_CKE cycles after `cke` rises. A precharge is followed by T_RP cycles, a register write by T_MRD cycles and an auto refresh by T_RFC cycles before the next command.
- R5: Command codes on {cs_n,ras_n,cas_n,we_n}: NOP=0111, precharge=0010, auto refresh=0001, mode register write=0000.
- R6: The extended register write drives `ba`=01 and `addr` = captured `ext_val` with bit 0 forced to 0 (loop enabled).
- R7: Both base register writes drive `ba`=00. The first drives the captured `mode_val` with bit 8 forced to 1 (loop reset). The last drives it with bit 8 forced to 0. Auto refresh drives `ba` and `addr` as 0.
- R8: `init_done` rises at the later of T_MRD cycles after the last register write and T_DLL cycles after the loop-reset write.
- R9: Once high, `init_done` stays high with `cke`=1 and NOP on the bus until reset.
- R10: `start` is ignored outside the idle state, and changes to `mode_val`/`ext_val` after the start cycle do not affect the commands.
- R11: Asserting `rst_n` low in the middle of the sequence returns the outputs to the R1 state at once. A later `start` runs the whole sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the sequence when the block is idle |
| mode_val | input | AW | Operating parameters for the base mode register |
| ext_val | input | AW | Contents for the extended mode register |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the register on mode writes |
| addr | output | AW | Address bus; register contents or the all-banks flag |
| init_done | output | 1 | Sequence complete |

## Verification
The hardest case is the rule that the ready flag waits out the loop lock time even when the command chain has already finished. With the default gaps, the chain ends long before the lock time has passed. A wrong ready condition therefore shows up only as a flag that comes too early. The bench predicts the ready cycle as the later of the two limits and scores it in the same queue as the commands. It also sends a second start pulse and changes the register inputs while the chain runs, then resets in the middle of a run and checks that the next run starts again from the beginning.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int AW       = 13,
  parameter int T_STABLE = 50000,
  parameter int T_CKE    = 2,
  parameter int T_RP     = 4,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 18,
  parameter int T_DLL    = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] mode_val,
  input  logic [AW-1:0] ext_val,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [1:0]    ba,
  output logic [AW-1:0] addr,
  output logic          init_done
);

  localparam int G_ST  = (T_STABLE < 1) ? 1 : T_STABLE;
  localparam int G_CKE = (T_CKE < 2) ? 2 : T_CKE;
  localparam int G_RP  = (T_RP  < 2) ? 2 : T_RP;
  localparam int G_MRD = (T_MRD < 2) ? 2 : T_MRD;
  localparam int G_RFC = (T_RFC < 2) ? 2 : T_RFC;
  localparam int G_DLL = (T_DLL < 1) ? 1 : T_DLL;
  localparam int M1    = (G_ST > G_RFC) ? G_ST : G_RFC;
  localparam int M2    = (M1 > G_RP) ? M1 : G_RP;
  localparam int M3    = (M2 > G_MRD) ? M2 : G_MRD;
  localparam int M4    = (M3 > G_CKE) ? M3 : G_CKE;
  localparam int CW    = $clog2(M4 + 1);
  localparam int DW    = $clog2(G_DLL + 1);
  localparam int DLL_RST_BIT = 8;
  localparam int DLL_DIS_BIT = 0;
  localparam int ALL_BIT     = 10;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef enum logic [3:0] {
    S_IDLE, S_STABLE, S_WAKE, S_PRE_A, S_EMRS, S_MRS_RST,
    S_PRE_B, S_REF_A, S_REF_B, S_MRS_RUN, S_GAP, S_DONE
  } st_t;

  st_t           st, nxt, follow;
  logic [CW-1:0] cnt, gap_len;
  logic [DW-1:0] dll_cnt;
  logic [AW-1:0] mode_q, ext_q;
  logic          dll_ok, is_cmd;
  logic [3:0]    cmd;

  assign dll_ok = dll_cnt >= DW'(G_DLL - 1);

  always_comb begin
    is_cmd  = 1'b1;
    gap_len = CW'(1);
    follow  = S_DONE;
    case (st)
      S_WAKE:    begin gap_len = CW'(G_CKE - 1); follow = S_PRE_A;   end
      S_PRE_A:   begin gap_len = CW'(G_RP  - 1); follow = S_EMRS;    end
      S_EMRS:    begin gap_len = CW'(G_MRD - 1); follow = S_MRS_RST; end
      S_MRS_RST: begin gap_len = CW'(G_MRD - 1); follow = S_PRE_B;   end
      S_PRE_B:   begin gap_len = CW'(G_RP  - 1); follow = S_REF_A;   end
      S_REF_A:   begin gap_len = CW'(G_RFC - 1); follow = S_REF_B;   end
      S_REF_B:   begin gap_len = CW'(G_RFC - 1); follow = S_MRS_RUN; end
      S_MRS_RUN: begin gap_len = CW'(G_MRD - 1); follow = S_DONE;    end
      default:   is_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      nxt    <= S_IDLE;
      cnt    <= '0;
      mode_q <= '0;
      ext_q  <= '0;
    end else if (is_cmd) begin
      st  <= S_GAP;
      cnt <= gap_len;
      nxt <= follow;
    end else begin
      case (st)
        S_IDLE:
          if (start) begin
            mode_q <= mode_val;
            ext_q  <= ext_val;
            cnt    <= CW'(G_ST);
            st     <= S_STABLE;
          end
        S_STABLE:
          if (cnt == CW'(1)) st <= S_WAKE;
          else cnt <= cnt - 1'b1;
        S_GAP:
          if (cnt == CW'(1)) begin
            if (nxt != S_DONE || dll_ok) st <= nxt;
          end else cnt <= cnt - 1'b1;
        default: st <= st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dll_cnt <= '0;
    else if (st == S_MRS_RST) dll_cnt <= DW'(1);
    else if (dll_cnt != '0 && dll_cnt < DW'(G_DLL)) dll_cnt <= dll_cnt + 1'b1;
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    case (st)
      S_PRE_A, S_PRE_B: begin cmd = C_PRE; addr[ALL_BIT] = 1'b1; end
      S_REF_A, S_REF_B: cmd = C_REF;
      S_EMRS: begin
        cmd = C_MRS; ba = 2'b01;
        addr = ext_q; addr[DLL_DIS_BIT] = 1'b0;
      end
      S_MRS_RST: begin
        cmd = C_MRS;
        addr = mode_q; addr[DLL_RST_BIT] = 1'b1;
      end
      S_MRS_RUN: begin
        cmd = C_MRS;
        addr = mode_q; addr[DLL_RST_BIT] = 1'b0;
      end
      default: cmd = C_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (st != S_IDLE) && (st != S_STABLE);
  assign init_done = (st == S_DONE);

  logic [DW-1:0] dll_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dll_seen <= '0;
    else if ({cs_n, ras_n, cas_n, we_n} == C_MRS && ba == 2'b00 && addr[DLL_RST_BIT])
      dll_seen <= DW'(1);
    else if (dll_seen != '0 && dll_seen < DW'(G_DLL)) dll_seen <= dll_seen + 1'b1;
  end

  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> {cs_n, ras_n, cas_n, we_n} == C_NOP); // R2
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done && {cs_n, ras_n, cas_n, we_n} == C_NOP); // R9
  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    {cs_n, ras_n, cas_n, we_n} == C_PRE |-> addr[ALL_BIT]); // R3
  AST_MRS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    {cs_n, ras_n, cas_n, we_n} == C_MRS |-> !ba[1]); // R6
  AST_DLL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> dll_seen >= DW'(G_DLL)); // R8

endmodule

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;

  localparam int AW   = 13;
  localparam int TST  = 300;
  localparam int TCKE = 2;
  localparam int TRP  = 4;
  localparam int TMRD = 2;
  localparam int TRFC = 18;
  localparam int TDLL = 200;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] mode_val = '0, ext_val = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int checks = 0, errors = 0;
  int pc = 0, t0 = 0;
  bit active = 0, done_seen = 0;

  typedef struct {
    int t; logic [3:0] cmd; logic [1:0] ba; logic [AW-1:0] a; bit done; string req;
  } item_t;
  item_t q[$];

  ddr_init_seq #(.AW(AW), .T_STABLE(TST), .T_CKE(TCKE), .T_RP(TRP), .T_MRD(TMRD),
                 .T_RFC(TRFC), .T_DLL(TDLL)) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_val(mode_val), .ext_val(ext_val),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done));

  always #2 clk = ~clk;
  always @(posedge clk) pc = pc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int t, input logic [3:0] c, input logic [1:0] b,
                      input logic [AW-1:0] a, input bit d, input string req);
    item_t it;
    it.t = t; it.cmd = c; it.ba = b; it.a = a; it.done = d; it.req = req;
    q.push_back(it);
  endtask

  task automatic run_init(input logic [AW-1:0] mv, input logic [AW-1:0] ev);
    int tp1, te, tr, tp2, tf1, tf2, tm, td;
    logic [AW-1:0] em, m1, m2;
    @(negedge clk);
    mode_val = mv; ext_val = ev; start = 1'b1;
    t0 = pc + 1; active = 1; done_seen = 0;
    em = ev; em[0] = 1'b0;
    m1 = mv; m1[8] = 1'b1;
    m2 = mv; m2[8] = 1'b0;
    tp1 = TST + TCKE; te = tp1 + TRP; tr = te + TMRD; tp2 = tr + TMRD;
    tf1 = tp2 + TRP; tf2 = tf1 + TRFC; tm = tf2 + TRFC;
    td = (tm + TMRD > tr + TDLL) ? tm + TMRD : tr + TDLL;
    push(tp1, 4'b0010, 2'b00, AW'(1) << 10, 0, "R3");
    push(te,  4'b0000, 2'b01, em, 0, "R6");
    push(tr,  4'b0000, 2'b00, m1, 0, "R7");
    push(tp2, 4'b0010, 2'b00, AW'(1) << 10, 0, "R3");
    push(tf1, 4'b0001, 2'b00, '0, 0, "R7");
    push(tf2, 4'b0001, 2'b00, '0, 0, "R7");
    push(tm,  4'b0000, 2'b00, m2, 0, "R7");
    push(td,  4'b0111, 2'b00, '0, 1, "R8");
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    int t;
    logic [3:0] c;
    item_t it;
    if (rst_n) begin
      t = pc - t0;
      c = {cs_n, ras_n, cas_n, we_n};
      if (active && t == TST - 1) chk(cke == 1'b0, "R2", "cke before wake", cke, 0);
      if (active && t == TST)     chk(cke == 1'b1, "R2", "cke at wake", cke, 1);
      if (c != 4'b0111) begin
        if (!active || q.size() == 0 || q[0].done) begin
          chk(0, "R3", "unexpected command", c, 4'b0111);
        end else begin
          it = q.pop_front();
          chk(it.t == t, "R4", "command cycle", t, it.t);
          chk(it.cmd == c, "R5", "command code", c, it.cmd);
          chk(it.ba == ba && it.a == addr, it.req, "bank/address",
              {ba, addr}, {it.ba, it.a});
        end
      end
      if (active && init_done && !done_seen) begin
        done_seen = 1;
        if (q.size() == 0 || !q[0].done) chk(0, "R8", "done too early", t, -1);
        else begin
          it = q.pop_front();
          chk(it.t == t, "R8", "init_done cycle", t, it.t);
        end
      end
    end
  end

  task automatic check_reset_state(input string req);
    chk(cke == 1'b0, req, "cke", cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, "command", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(ba == 2'b00 && addr == '0, req, "bank/address", {ba, addr}, 0);
    chk(init_done == 1'b0, req, "init_done", init_done, 0);
  endtask

  task automatic wait_done();
    while (!init_done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R3", "items left in queue", q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; active = 0; q.delete();
    #1;
    check_reset_state("R11");
    @(negedge clk);
    check_reset_state("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check_reset_state("R1");

    // Main run; inputs change and start pulses again mid-sequence (R10)
    run_init(13'h0062, 13'h0003);
    repeat (100) @(negedge clk);
    mode_val = 13'h1fff; ext_val = 13'h0aaa; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (250) @(negedge clk);
    start = 1'b1; mode_val = 13'h0000;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(init_done && cke && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R9",
          "done hold", {init_done, cke, cs_n, ras_n, cas_n, we_n}, 6'b110111);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(init_done == 1'b1, "R10", "start after done", init_done, 1);

    // Reset in the middle, then restart (R11)
    do_reset();
    run_init(13'h1532, 13'h0ffe);
    repeat (TST + 20) @(negedge clk);
    do_reset();
    repeat (10) @(negedge clk);
    check_reset_state("R1");
    run_init(13'h0133, 13'h1001);
    wait_done();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule